// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Gated Interrupt Request

This block is a watchdog timer that answers a hang in two steps. A programmable down-counter runs from a prescaled clock. The first time it runs out, the block sets a timeout flag. If both the watchdog's own interrupt enable and the global interrupt enable are on, it also sends a one-cycle system-management interrupt request, so firmware gets a chance to recover. The counter then reloads and keeps running. If it runs out a second time while the timeout flag is still set, the block asserts a system reset output. That output stays on until the block itself is reset.

Software reaches the block through a byte-addressed register port. Writes take effect on the clock edge, and reads are combinational. The interrupt enable register sits at byte address 0x30, and the watchdog registers start at 0x60. Software keeps the system alive in one of two ways. It can write to the counter address, which reloads the counter from the programmed reload value. Or it can clear the timeout flag by writing one to it, which stops the second expiry from turning into a reset. A halt bit freezes the counter. That bit is set out of reset, so the watchdog does nothing until software releases it.

Top module: `dual_stage_wdt`

## Requirements
- R1: After reset, `smi_req` and `sys_rst_out` are 0, and the halt bit is 1. The counter reads `RELOAD_RST`, the reload value is `RELOAD_RST`, the timeout flag is 0 and both interrupt enables are 0.
- R2: The control register at 0x68 holds the halt bit at bit 11. While that bit is 1 the counter value does not change, except through a keepalive write.
- R3: While running, the counter steps down by one every `PRESCALE` cycles. It expires on the tick where it is already 0, then reloads. The first expiry comes `(reload+1)*PRESCALE` cycles after the halt bit is cleared, and it sets the timeout flag (bit 3 of the status register at 0x64).
- R4: The interrupt enable register at 0x30 keeps only bit 13 (watchdog interrupt enable) and bit 0 (global interrupt enable); all other bits read 0. An expiry that finds the flag clear raises `smi_req` for exactly one cycle when both bits are 1.
- R5: When bit 13 of 0x30 is 0, `smi_req` stays 0, but the timeout flag is still set on expiry.
- R6: When bit 0 of 0x30 is 0, `smi_req` stays 0, but the timeout flag is still set on expiry.
- R7: An expiry that finds the timeout flag already set asserts `sys_rst_out` instead of `smi_req`. `sys_rst_out` stays 1 until `rst_n` is applied.
- R8: Writing a value with bit 3 set to 0x64 clears the timeout flag, and writing 0 there has no effect. If the flag is cleared before the next expiry, that expiry raises an interrupt again instead of a reset. An expiry in the same cycle as a clear write leaves the flag set.
- R9: A write of any data to 0x60 loads the counter from the reload register at 0x6C and leaves the timeout flag unchanged. Writing 0x6C alone does not change the counter. Reading 0x60 returns the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data |
| smi_req | output | 1 | One-cycle interrupt request on a first-stage expiry |
| sys_rst_out | output | 1 | Sticky system reset request on a second-stage expiry |

## Verification
The bench measures the exact cycle of the first expiry. A counter that is off by one in its reload or prescaler would show up as a request one tick early or late. It runs the timer through a second expiry to confirm that the reset comes on the second expiry and not the first, and that it stays on afterwards. The other cases are checked the same way:
- Each interrupt enable is turned off by itself, to catch a design that uses OR instead of AND on the gating.
- A zero write to the status register must not clear the flag.
- A keepalive must not disturb the flag, and a properly timed clear must turn the next expiry back into an interrupt.
- Reading the count while halted catches a counter that ignores the halt bit.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
   // Byte addresses seen on the register port
   localparam int unsigned SMIEN_ADDR = 'h30;
   localparam int unsigned WDT_BASE   = 'h60;
   localparam int unsigned CNT_ADDR   = WDT_BASE + 'h0;
   localparam int unsigned STS_ADDR   = WDT_BASE + 'h4;
   localparam int unsigned CTL_ADDR   = WDT_BASE + 'h8;
   localparam int unsigned RLD_ADDR   = WDT_BASE + 'hC;

   // Bit positions inside those registers
   localparam int unsigned WDT_IEN_BIT = 13;
   localparam int unsigned GLB_IEN_BIT = 0;
   localparam int unsigned TMO_BIT     = 3;
   localparam int unsigned HALT_BIT    = 11;

   typedef struct packed {
      logic wdt_ien;
      logic glb_ien;
      logic halt;
   } dsw_cfg_t;
endpackage

// File: rtl/dsw_regs.sv
module dsw_regs
   import dsw_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CNT_W      = 10,
   parameter int unsigned RELOAD_RST = 600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              tmo_flag,
   output logic [DATA_W-1:0] rdata,
   output dsw_cfg_t          cfg,
   output logic [CNT_W-1:0]  reload_val,
   output logic              ka_pulse,
   output logic              tmo_clr
);
   localparam logic [ADDR_W-1:0] A_SMIEN = ADDR_W'(SMIEN_ADDR);
   localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(CNT_ADDR);
   localparam logic [ADDR_W-1:0] A_STS   = ADDR_W'(STS_ADDR);
   localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(CTL_ADDR);
   localparam logic [ADDR_W-1:0] A_RLD   = ADDR_W'(RLD_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.wdt_ien <= 1'b0;
         cfg.glb_ien <= 1'b0;
         cfg.halt    <= 1'b1;
         reload_val  <= CNT_W'(RELOAD_RST);
      end else if (we) begin
         if (addr == A_SMIEN) begin
            cfg.wdt_ien <= wdata[WDT_IEN_BIT];
            cfg.glb_ien <= wdata[GLB_IEN_BIT];
         end
         if (addr == A_CTL) cfg.halt <= wdata[HALT_BIT];
         if (addr == A_RLD) reload_val <= wdata[CNT_W-1:0];
      end
   end

   assign ka_pulse = we && (addr == A_CNT);
   assign tmo_clr  = we && (addr == A_STS) && wdata[TMO_BIT];

   always_comb begin
      rdata = '0;
      if (addr == A_SMIEN) begin
         rdata[WDT_IEN_BIT] = cfg.wdt_ien;
         rdata[GLB_IEN_BIT] = cfg.glb_ien;
      end else if (addr == A_CNT) begin
         rdata[CNT_W-1:0] = count;
      end else if (addr == A_STS) begin
         rdata[TMO_BIT] = tmo_flag;
      end else if (addr == A_CTL) begin
         rdata[HALT_BIT] = cfg.halt;
      end else if (addr == A_RLD) begin
         rdata[CNT_W-1:0] = reload_val;
      end
   end
endmodule

// File: rtl/dsw_tick.sv
module dsw_tick #(
   parameter int unsigned PRESCALE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (PRESCALE == 1) begin : g_direct
         assign tick = run;
      end else begin : g_div
         localparam int unsigned PW = $clog2(PRESCALE);
         localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
         logic [PW-1:0] phase;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              phase <= '0;
            else if (!run)           phase <= '0;
            else if (phase == LAST)  phase <= '0;
            else                     phase <= phase + 1'b1;
         end
         assign tick = run && (phase == LAST);
      end
   endgenerate
endmodule

// File: rtl/dsw_counter.sv
module dsw_counter #(
   parameter int unsigned CNT_W      = 10,
   parameter int unsigned RELOAD_RST = 600
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   assign expire = tick && (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= CNT_W'(RELOAD_RST);
      else if (load)    count <= reload_val;
      else if (expire)  count <= reload_val;
      else if (tick)    count <= count - 1'b1;
   end
endmodule

// File: rtl/dsw_stage.sv
module dsw_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic tmo_clr,
   input  logic wdt_ien,
   input  logic glb_ien,
   output logic tmo_flag,
   output logic smi_req,
   output logic sys_rst
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_flag <= 1'b0;
         smi_req  <= 1'b0;
         sys_rst  <= 1'b0;
      end else begin
         smi_req <= 1'b0;
         if (expire) begin
            tmo_flag <= 1'b1;
            if (tmo_flag) sys_rst <= 1'b1;
            else          smi_req <= wdt_ien & glb_ien;
         end else if (tmo_clr) begin
            tmo_flag <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt
   import dsw_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CNT_W      = 10,
   parameter int unsigned PRESCALE   = 4,
   parameter int unsigned RELOAD_RST = 600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              smi_req,
   output logic              sys_rst_out
);
   generate
      if (ADDR_W < 7)                 begin : g_bad_addr  $error("ADDR_W too small for map"); end
      if (DATA_W < 14)                begin : g_bad_data  $error("DATA_W must hold bit 13"); end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt   $error("CNT_W out of range"); end
      if (PRESCALE < 1)               begin : g_bad_pre   $error("PRESCALE must be >= 1"); end
      if (RELOAD_RST >= (1 << CNT_W)) begin : g_bad_rld   $error("RELOAD_RST exceeds CNT_W"); end
   endgenerate

   dsw_cfg_t         cfg;
   logic [CNT_W-1:0] count, reload_val;
   logic             ka_pulse, tmo_clr, tick, expire, tmo_flag;
   logic             cfg_halt, cfg_wdt_ien, cfg_glb_ien;

   assign cfg_halt    = cfg.halt;
   assign cfg_wdt_ien = cfg.wdt_ien;
   assign cfg_glb_ien = cfg.glb_ien;

   dsw_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .count(count), .tmo_flag(tmo_flag), .rdata(reg_rdata), .cfg(cfg),
      .reload_val(reload_val), .ka_pulse(ka_pulse), .tmo_clr(tmo_clr)
   );

   dsw_tick #(.PRESCALE(PRESCALE)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(!cfg_halt), .tick(tick)
   );

   dsw_counter #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(ka_pulse),
      .reload_val(reload_val), .count(count), .expire(expire)
   );

   dsw_stage u_stage (
      .clk(clk), .rst_n(rst_n), .expire(expire), .tmo_clr(tmo_clr),
      .wdt_ien(cfg_wdt_ien), .glb_ien(cfg_glb_ien),
      .tmo_flag(tmo_flag), .smi_req(smi_req), .sys_rst(sys_rst_out)
   );
endmodule

// File: rtl/dual_stage_wdt_chk.sv
module dual_stage_wdt_chk #(
   parameter int unsigned CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smi_req,
   input logic             sys_rst_out,
   input logic             tmo_flag,
   input logic             halt,
   input logic             wdt_ien,
   input logic             glb_ien,
   input logic             ka_pulse,
   input logic [CNT_W-1:0] count
);
   AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !ka_pulse) |=> $stable(count));                              // R2
   AST_SMI_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      smi_req |-> tmo_flag);                                                // R3
   AST_SMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      smi_req |=> !smi_req);                                                // R4
   AST_SMI_WDT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      smi_req |-> $past(wdt_ien));                                          // R5
   AST_SMI_GLB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      smi_req |-> $past(glb_ien));                                          // R6
   AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_out |=> sys_rst_out);                                         // R7
   AST_RST_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_out) |-> $past(tmo_flag));                              // R7
   AST_SMI_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      smi_req |-> !$past(tmo_flag));                                        // R8
endmodule

bind dual_stage_wdt dual_stage_wdt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .sys_rst_out(sys_rst_out),
   .tmo_flag(tmo_flag), .halt(cfg_halt), .wdt_ien(cfg_wdt_ien),
   .glb_ien(cfg_glb_ien), .ka_pulse(ka_pulse), .count(count)
);

// File: tb/dual_stage_wdt_test.sv
module dual_stage_wdt_test;
   localparam int unsigned AW = 8;
   localparam int unsigned DW = 32;
   localparam int unsigned PRE = 2;
   localparam int unsigned RST_LOAD = 40;
   localparam logic [7:0] A_EN = 8'h30, A_CNT = 8'h60, A_STS = 8'h64,
                          A_CTL = 8'h68, A_RLD = 8'h6C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          smi, srst;
   int            checks = 0;
   int            errors = 0;

   always #10 clk = ~clk;

   dual_stage_wdt #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(10), .PRESCALE(PRE),
                    .RELOAD_RST(RST_LOAD)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .smi_req(smi), .sys_rst_out(srst)
   );

   typedef struct packed {
      logic        wr;
      logic [7:0]  a;
      logic [31:0] d;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'h30, 32'h0000_2001, 8'd4},   // R4 enable both
      '{1'b0, 8'h30, 32'h0000_2001, 8'd4},   // R4 read back
      '{1'b1, 8'h6C, 32'h0000_0007, 8'd9},   // R9 program reload
      '{1'b0, 8'h6C, 32'h0000_0007, 8'd9},   // R9 reload read back
      '{1'b0, 8'h60, 32'd40,        8'd9},   // R9 count untouched by reload write
      '{1'b1, 8'h60, 32'h0000_0000, 8'd9},   // R9 keepalive
      '{1'b0, 8'h60, 32'h0000_0007, 8'd9},   // R9 count reloaded
      '{1'b0, 8'h68, 32'h0000_0800, 8'd2},   // R2 halt bit 11 set
      '{1'b1, 8'h30, 32'hFFFF_FFFF, 8'd4},   // R4 write all ones
      '{1'b0, 8'h30, 32'h0000_2001, 8'd4},   // R4 only two bits kept
      '{1'b0, 8'h64, 32'h0000_0000, 8'd8}    // R8 flag clear
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // callers are at a negedge; one clock edge is consumed
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // arm with given enables, reload 5, release halt; returns after edge E0
   task automatic arm(input logic [31:0] en);
      wr(A_EN, en);
      wr(A_RLD, 32'd5);
      wr(A_CNT, 32'd0);
      wr(A_CTL, 32'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] v, v2;
      int first_smi, first_rst, smi_cyc;

      do_reset();
      // R1 reset state
      chk("R1 smi", {31'b0, smi}, 32'd0);
      chk("R1 rst", {31'b0, srst}, 32'd0);
      rd(A_CTL, v); chk("R1 halt", v, 32'h800);
      rd(A_CNT, v); chk("R1 count", v, RST_LOAD);
      rd(A_RLD, v); chk("R1 reload", v, RST_LOAD);
      rd(A_STS, v); chk("R1 flag", v, 32'd0);
      rd(A_EN, v);  chk("R1 enables", v, 32'd0);

      // vector table over the register port (halted)
      for (int i = 0; i < NV; i++) begin
         if (VECS[i].wr) begin
            wr(VECS[i].a, VECS[i].d);
         end else begin
            rd(VECS[i].a, v);
            chk($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].d);
         end
      end

      // R2: halted counter stays put
      wr(A_RLD, 32'd5);
      wr(A_CNT, 32'd0);
      repeat (10) @(negedge clk);
      rd(A_CNT, v); chk("R2 halted count", v, 32'd5);

      // R3 R4 R7: first expiry timing, single pulse, reset on second
      wr(A_EN, 32'h2001);
      wr(A_CTL, 32'd0);
      first_smi = -1; first_rst = -1; smi_cyc = 0;
      for (int n = 1; n <= 40; n++) begin
         @(negedge clk);
         if (smi) begin
            smi_cyc++;
            if (first_smi < 0) begin
               first_smi = n;
               rd(A_STS, v); chk("R3 flag at first expiry", v, 32'h8);
            end
         end
         if (srst && first_rst < 0) first_rst = n;
      end
      chk("R3 first expiry cycle", first_smi, (5 + 1) * PRE);
      chk("R4 smi pulse width", smi_cyc, 32'd1);
      chk("R7 reset on second expiry", first_rst, 2 * (5 + 1) * PRE);
      chk("R7 reset sticky", {31'b0, srst}, 32'd1);

      // R8 R9: clear flag in time avoids reset
      do_reset();
      chk("R7 reset cleared by rst_n", {31'b0, srst}, 32'd0);
      arm(32'h2001);
      smi_cyc = 0;
      for (int n = 1; n <= 12; n++) begin
         @(negedge clk);
         if (smi) smi_cyc++;
      end
      chk("R4 smi at first expiry", smi_cyc, 32'd1);
      wr(A_STS, 32'd0);
      rd(A_STS, v); chk("R8 zero write keeps flag", v, 32'h8);
      wr(A_CNT, 32'd0);
      rd(A_CNT, v);  chk("R9 keepalive reloads", v, 32'd5);
      rd(A_STS, v2); chk("R9 keepalive keeps flag", v2, 32'h8);
      wr(A_STS, 32'h8);
      rd(A_STS, v); chk("R8 one write clears flag", v, 32'd0);
      smi_cyc = 0;
      for (int n = 1; n <= 20; n++) begin
         @(negedge clk);
         if (smi) smi_cyc++;
      end
      chk("R8 no reset after clear", {31'b0, srst}, 32'd0);
      chk("R8 expiry gives smi again", smi_cyc, 32'd1);
      rd(A_STS, v); chk("R8 flag set again", v, 32'h8);

      // R5: watchdog interrupt enable off
      do_reset();
      arm(32'h0001);
      smi_cyc = 0;
      for (int n = 1; n <= 14; n++) begin
         @(negedge clk);
         if (smi) smi_cyc++;
      end
      chk("R5 no smi", smi_cyc, 32'd0);
      rd(A_STS, v); chk("R5 flag still set", v, 32'h8);

      // R6: global enable off; then R2 halt while running
      do_reset();
      arm(32'h2000);
      smi_cyc = 0;
      for (int n = 1; n <= 14; n++) begin
         @(negedge clk);
         if (smi) smi_cyc++;
      end
      chk("R6 no smi", smi_cyc, 32'd0);
      rd(A_STS, v); chk("R6 flag still set", v, 32'h8);
      wr(A_CTL, 32'h800);
      rd(A_CNT, v);
      repeat (6) @(negedge clk);
      rd(A_CNT, v2); chk("R2 halt freezes running count", v2, v);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule